// File: doc/BRIEF.md
# Control Register Zero Write Unit

This block executes the two instructions that write the processor's CR0 model. The first is the legacy status-word load, which touches only the four low flags (protection enable, monitor coprocessor, emulation, task switched). The second is the full 32-bit control-register move. The block receives an already-decoded request: two opcode bytes, the ModRM reg field, a LOCK flag and the source operand. It also receives the current execution mode, the privilege level and the memory-fault indications raised by the address path.

A request is accepted on a valid/ready handshake. One cycle later the block presents a registered response. The response carries the updated CR0, a pulse that marks entry into protected mode, a serialize request and a one-hot exception vector with its error code. When a request faults, CR0 keeps its value. Instruction fetch, segmentation, paging and the FPU lie outside the block.

Mode encoding on `cpu_mode`: 0 real-address, 1 protected (compatibility included), 2 virtual-8086, 3 64-bit.

Top module: `cr0_write_unit`

## Requirements
- R1: Bytes 0F 01 with reg field 6 select the legacy load. Bytes 0F 22 with reg field 0 select the full load. Any other request raises #UD.
- R2: The legacy load writes source bits 3:1 into CR0[3:1]. CR0[31:4] is left unchanged, and source bits 31:4 have no effect.
- R3: The legacy load sets the new CR0[0] to the old CR0[0] OR source bit 0, so it can set protection enable but never clear it.
- R4: `pe_switch` is high in the response of a successful write that takes CR0[0] from 0 to 1. In every other response it is low.
- R5: The full load copies all 32 source bits into CR0 and can clear CR0[0].
- R6: In modes 1 and 3, a privilege level other than 0 raises #GP with error code 0.
- R7: In mode 2, both instructions raise #GP with error code 0 at any privilege level.
- R8: A LOCK prefix raises #UD in every mode, ahead of every other exception.
- R9: Mode 0 performs no privilege check. Memory faults apply only to the legacy load and are reported in this order: stack (#SS, code 0), then segment limit or non-canonical address (#GP, code 0), then page fault (#PF, code taken from `pf_code`). The full load ignores memory-fault inputs.
- R10: `exc_vec` is one-hot or zero: bit 0 #UD, bit 1 #GP, bit 2 #SS, bit 3 #PF. A faulting request leaves CR0 unchanged and gives `serialize` low. A successful one gives `serialize` high and `exc_code` 0.
- R11: The response appears one cycle after acceptance. It is held while `rsp_ready` is low, and `req_ready` equals `!rsp_valid || rsp_ready`.
- R12: After reset, CR0 is 0x00000010 and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| op_byte0 | input | 8 | First opcode byte |
| op_byte1 | input | 8 | Second opcode byte |
| modrm_reg | input | 3 | ModRM reg field |
| lock_prefix | input | 1 | LOCK prefix present |
| src_data | input | 32 | Source operand |
| cpu_mode | input | 2 | Execution mode |
| cpl | input | 2 | Current privilege level |
| seg_fault | input | 1 | Segment limit or null selector fault |
| stack_fault | input | 1 | Stack segment limit fault |
| page_fault | input | 1 | Page fault on operand |
| noncanon_fault | input | 1 | Non-canonical operand address |
| pf_code | input | 16 | Page-fault error code |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_valid | output | 1 | Response present |
| cr0 | output | 32 | Current CR0 value |
| pe_switch | output | 1 | Entry into protected mode |
| serialize | output | 1 | Serialize request |
| exc_vec | output | 4 | One-hot exception |
| exc_code | output | 16 | Exception error code |

## Verification
Every result (CR0, `pe_switch`, `serialize`, `exc_vec`, `exc_code`) is due exactly one clock edge after the edge that accepts a request. The bench drives each request on a falling edge. It lets one rising edge accept the request and reads all outputs on the next falling edge. By then the accepting edge has loaded the response registers and no second edge has passed. The backpressure scenario reads at two further falling edges, to confirm that the response is held and that `req_ready` drops.

// File: rtl/cr0_write_unit.sv
module cr0_write_unit #(
  parameter logic [31:0] CR0_RESET = 32'h0000_0010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  op_byte0,
  input  logic [7:0]  op_byte1,
  input  logic [2:0]  modrm_reg,
  input  logic        lock_prefix,
  input  logic [31:0] src_data,
  input  logic [1:0]  cpu_mode,
  input  logic [1:0]  cpl,
  input  logic        seg_fault,
  input  logic        stack_fault,
  input  logic        page_fault,
  input  logic        noncanon_fault,
  input  logic [15:0] pf_code,
  input  logic        rsp_ready,
  output logic        rsp_valid,
  output logic [31:0] cr0,
  output logic        pe_switch,
  output logic        serialize,
  output logic [3:0]  exc_vec,
  output logic [15:0] exc_code
);
  localparam logic [1:0] MODE_REAL = 2'd0;
  localparam logic [1:0] MODE_V86  = 2'd2;

  logic accept, is_legacy, is_full, raise_ud, raise_priv, mem_ss, mem_gp, mem_pf;
  logic [3:0] nxt_exc;
  logic [15:0] nxt_code;
  logic [31:0] nxt_cr0;
  logic fresh, fresh_legacy;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept = req_valid && req_ready;

  assign is_legacy = op_byte0 == 8'h0F && op_byte1 == 8'h01 && modrm_reg == 3'd6;
  assign is_full   = op_byte0 == 8'h0F && op_byte1 == 8'h22 && modrm_reg == 3'd0;

  assign raise_ud   = lock_prefix || !(is_legacy || is_full);
  assign raise_priv = cpu_mode == MODE_V86 || (cpu_mode != MODE_REAL && cpl != 2'd0);
  assign mem_ss = is_legacy && stack_fault;
  assign mem_gp = is_legacy && (seg_fault || noncanon_fault);
  assign mem_pf = is_legacy && page_fault;

  always_comb begin
    nxt_exc  = 4'b0000;
    nxt_code = 16'h0000;
    if (raise_ud)        nxt_exc = 4'b0001;
    else if (raise_priv) nxt_exc = 4'b0010;
    else if (mem_ss)     nxt_exc = 4'b0100;
    else if (mem_gp)     nxt_exc = 4'b0010;
    else if (mem_pf) begin
      nxt_exc  = 4'b1000;
      nxt_code = pf_code;
    end
  end

  assign nxt_cr0 = is_legacy ? {cr0[31:4], src_data[3:1], cr0[0] | src_data[0]} : src_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr0          <= CR0_RESET;
      rsp_valid    <= 1'b0;
      pe_switch    <= 1'b0;
      serialize    <= 1'b0;
      exc_vec      <= 4'b0000;
      exc_code     <= 16'h0000;
      fresh        <= 1'b0;
      fresh_legacy <= 1'b0;
    end else begin
      fresh        <= accept;
      fresh_legacy <= accept && is_legacy && nxt_exc == 4'b0000;
      if (accept) begin
        rsp_valid <= 1'b1;
        exc_vec   <= nxt_exc;
        exc_code  <= nxt_code;
        serialize <= nxt_exc == 4'b0000;
        pe_switch <= nxt_exc == 4'b0000 && !cr0[0] && nxt_cr0[0];
        if (nxt_exc == 4'b0000) cr0 <= nxt_cr0;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assert_exc_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(exc_vec));
  assert_fault_keeps_cr0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fresh && exc_vec != 4'b0000 |-> $stable(cr0));
  assert_upper_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_legacy |-> cr0[31:4] == $past(cr0[31:4]));
  assert_pe_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_legacy |-> !$fell(cr0[0]));
  assert_switch_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fresh && pe_switch |-> $rose(cr0[0]));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready && !accept |=> rsp_valid && $stable(exc_vec) && $stable(cr0));
endmodule

// File: tb/cr0_write_unit_test.sv
module cr0_write_unit_test;
  logic clk = 0, rst_n = 0, req_valid = 0, lock_prefix = 0, rsp_ready = 1;
  logic [7:0] op_byte0 = 0, op_byte1 = 0;
  logic [2:0] modrm_reg = 0;
  logic [31:0] src_data = 0;
  logic [1:0] cpu_mode = 0, cpl = 0;
  logic seg_fault = 0, stack_fault = 0, page_fault = 0, noncanon_fault = 0;
  logic [15:0] pf_code = 0;
  logic req_ready, rsp_valid, pe_switch, serialize;
  logic [31:0] cr0;
  logic [3:0] exc_vec;
  logic [15:0] exc_code;
  int checks = 0, errors = 0;

  cr0_write_unit uut (.*);

  always #4 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [7:0] b1, logic [2:0] rg, logic lk, logic [31:0] src,
                       logic [1:0] md, logic [1:0] pl, logic [3:0] flt, logic [15:0] pfc);
    @(negedge clk);
    op_byte0 = 8'h0F; op_byte1 = b1; modrm_reg = rg; lock_prefix = lk; src_data = src;
    cpu_mode = md; cpl = pl; {noncanon_fault, page_fault, stack_fault, seg_fault} = flt;
    pf_code = pfc; req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    {noncanon_fault, page_fault, stack_fault, seg_fault} = 4'b0;
  endtask

  task automatic expect_rsp(string tag, logic [31:0] c, logic [3:0] ex, logic [15:0] code,
                            logic ser, logic sw);
    check({tag, " valid"}, rsp_valid, 1);
    check({tag, " cr0"}, cr0, c);
    check({tag, " exc"}, exc_vec, ex);
    check({tag, " code"}, exc_code, code);
    check({tag, " serialize"}, serialize, ser);
    check({tag, " pe_switch"}, pe_switch, sw);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R12 cr0 reset", cr0, 32'h10);
    check("R12 valid reset", rsp_valid, 0);
    check("R11 ready idle", req_ready, 1);
  endtask

  task automatic t_legacy_partial();
    issue(8'h01, 3'd6, 0, 32'hABCD_FFFE, 2'd0, 2'd3, 4'b0, 16'h0);
    expect_rsp("R2 R9 legacy real cpl3", 32'h1E, 4'b0, 16'h0, 1, 0);
  endtask

  task automatic t_full_write();
    issue(8'h22, 3'd0, 0, 32'h8000_0010, 2'd0, 2'd0, 4'b0, 16'h0);
    expect_rsp("R5 full write", 32'h8000_0010, 4'b0, 16'h0, 1, 0);
  endtask

  task automatic t_enter_protected();
    issue(8'h01, 3'd6, 0, 32'h0000_0001, 2'd0, 2'd0, 4'b0, 16'h0);
    expect_rsp("R4 pe rise", 32'h8000_0011, 4'b0, 16'h0, 1, 1);
    issue(8'h01, 3'd6, 0, 32'h0000_000E, 2'd1, 2'd0, 4'b0, 16'h0);
    expect_rsp("R2 R4 prot flags", 32'h8000_001F, 4'b0, 16'h0, 1, 0);
    issue(8'h01, 3'd6, 0, 32'h0000_0000, 2'd1, 2'd0, 4'b0, 16'h0);
    expect_rsp("R3 pe sticky", 32'h8000_0011, 4'b0, 16'h0, 1, 0);
  endtask

  task automatic t_privilege();
    issue(8'h01, 3'd6, 0, 32'h0000_000F, 2'd1, 2'd3, 4'b0, 16'h0);
    expect_rsp("R6 cpl3 prot", 32'h8000_0011, 4'b0010, 16'h0, 0, 0);
    issue(8'h22, 3'd0, 0, 32'h0, 2'd3, 2'd1, 4'b0, 16'h0);
    expect_rsp("R6 cpl1 64bit full", 32'h8000_0011, 4'b0010, 16'h0, 0, 0);
    issue(8'h01, 3'd6, 0, 32'h0000_000F, 2'd2, 2'd0, 4'b0, 16'h0);
    expect_rsp("R7 v86 cpl0", 32'h8000_0011, 4'b0010, 16'h0, 0, 0);
  endtask

  task automatic t_undefined();
    issue(8'h01, 3'd6, 1, 32'h0000_000F, 2'd2, 2'd3, 4'b0110, 16'h0);
    expect_rsp("R8 lock first", 32'h8000_0011, 4'b0001, 16'h0, 0, 0);
    issue(8'h01, 3'd6, 1, 32'h0000_000F, 2'd0, 2'd0, 4'b0, 16'h0);
    expect_rsp("R8 lock real", 32'h8000_0011, 4'b0001, 16'h0, 0, 0);
    issue(8'h01, 3'd7, 0, 32'h0000_000F, 2'd1, 2'd0, 4'b0, 16'h0);
    expect_rsp("R1 bad reg", 32'h8000_0011, 4'b0001, 16'h0, 0, 0);
    issue(8'h22, 3'd3, 0, 32'h0, 2'd0, 2'd0, 4'b0, 16'h0);
    expect_rsp("R1 other cr", 32'h8000_0011, 4'b0001, 16'h0, 0, 0);
  endtask

  task automatic t_memory_faults();
    issue(8'h01, 3'd6, 0, 32'h0000_000F, 2'd1, 2'd0, 4'b0111, 16'h0005);
    expect_rsp("R9 ss first", 32'h8000_0011, 4'b0100, 16'h0, 0, 0);
    issue(8'h01, 3'd6, 0, 32'h0000_000F, 2'd1, 2'd0, 4'b0101, 16'h0005);
    expect_rsp("R9 seg over pf", 32'h8000_0011, 4'b0010, 16'h0, 0, 0);
    issue(8'h01, 3'd6, 0, 32'h0000_000F, 2'd1, 2'd0, 4'b0100, 16'h0007);
    expect_rsp("R9 pf code", 32'h8000_0011, 4'b1000, 16'h0007, 0, 0);
    issue(8'h01, 3'd6, 0, 32'h0000_000F, 2'd3, 2'd0, 4'b1000, 16'h0);
    expect_rsp("R9 noncanon", 32'h8000_0011, 4'b0010, 16'h0, 0, 0);
    issue(8'h01, 3'd6, 0, 32'h0000_000F, 2'd1, 2'd3, 4'b0100, 16'h0007);
    expect_rsp("R6 R9 priv over pf", 32'h8000_0011, 4'b0010, 16'h0, 0, 0);
    issue(8'h01, 3'd6, 0, 32'h0000_000F, 2'd0, 2'd3, 4'b0001, 16'h0);
    expect_rsp("R9 real seg", 32'h8000_0011, 4'b0010, 16'h0, 0, 0);
  endtask

  task automatic t_full_clear();
    issue(8'h22, 3'd0, 0, 32'h0000_0010, 2'd1, 2'd0, 4'b0100, 16'h0009);
    expect_rsp("R5 R9 full clears pe", 32'h10, 4'b0, 16'h0, 1, 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 0;
    issue(8'h01, 3'd6, 0, 32'h0000_0003, 2'd0, 2'd0, 4'b0, 16'h0);
    expect_rsp("R11 first", 32'h13, 4'b0, 16'h0, 1, 1);
    check("R11 ready low", req_ready, 0);
    req_valid = 1; op_byte1 = 8'h22; modrm_reg = 0; src_data = 32'h0;
    @(negedge clk);
    check("R11 held valid", rsp_valid, 1);
    check("R11 held cr0", cr0, 32'h13);
    check("R11 held switch", pe_switch, 1);
    req_valid = 0; rsp_ready = 1;
    @(negedge clk);
    check("R11 released", rsp_valid, 0);
    check("R11 cr0 after release", cr0, 32'h13);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_legacy_partial();
    t_full_write();
    t_enter_protected();
    t_privilege();
    t_undefined();
    t_memory_faults();
    t_full_clear();
    t_backpressure();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule